// File: doc/BRIEF.md
# Shared Memory Bank Conflict Resolver

This block serves one warp-wide access to a banked on-chip scratchpad. A request carries one word address per lane, an active-lane mask and a read/write flag. The block works out which bank each lane falls in, then splits the access into serial passes. In each pass every bank handles at most one distinct word. Lanes that want the same word are served together in that pass, so a broadcast costs nothing extra. Each pass drives per-bank enables and row addresses into synchronous single-port bank memories. Read data is put back at each lane's own position.

The cost of an access is the largest number of distinct words that the active lanes request from any one bank. A conflict-free access therefore takes one pass. An N-way conflict takes N passes. The pass count is reported when the access completes, together with a one-cycle completion pulse. A single busy flag covers the whole operation, and requests that arrive while it is high are dropped.

Top module: `bank_conflict_resolver`

## Requirements
- R1: A lane's bank is its word address modulo BANKS (the low log2(BANKS) address bits). The remaining upper bits select the row within that bank.
- R2: When every active lane addresses a different bank, the reported cycle count is 1.
- R3: The reported cycle count equals the maximum, over all banks, of the number of distinct word addresses requested in that bank by active lanes. An N-way conflict reports N.
- R4: Active lanes that request the identical word are served in the same pass, and they add no cycles.
- R5: Lanes whose mask bit is 0 take no part in bank selection or cost, and their read data is returned as 0.
- R6: After a request is accepted, busy is high for max(P,1)+2 cycles, where P is the pass count. On the cycle busy falls, done is high for exactly one cycle and cycles shows P. cycles then holds until the next completion.
- R7: For a read, each active lane receives the stored word at its own address in its own DATA_W slice of rdata. Lane l occupies bits [l*DATA_W +: DATA_W].
- R8: A write follows the same pass rule as a read, and a write returns rdata of all zeros. When several active lanes write the same word, the data of the lowest-numbered of those lanes is stored.
- R9: A request presented while busy is high is ignored: it neither changes memory nor starts an operation.
- R10: After reset, busy, done, cycles, bank_en and rdata are all 0.
- R11: A request with an empty mask reports 0 cycles and completes with busy high for 3 cycles.
- R12: bank_en is all zeros whenever busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe; taken only while busy is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mask | input | LANES | Active-lane mask |
| req_addr | input | LANES*ADDR_W | Word address per lane; lane l at [l*ADDR_W +: ADDR_W] |
| req_wdata | input | LANES*DATA_W | Write data per lane |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| cycles | output | CNT_W | Pass count of the last completed access |
| bank_en | output | BANKS | Per-bank enable of the current pass |
| bank_row | output | BANKS*ROW_W | Per-bank row address of the current pass |
| rdata | output | LANES*DATA_W | Per-lane read data |

## Verification
The access patterns are chosen so that each one separates a different part of the pass rule:
- **Unit stride** must cost one pass.
- **Stride two** must cost two passes; a design that ignores conflicts would report one.
- **Lanes folded onto one bank**, with pairs sharing a word, must cost the number of distinct words rather than the number of lanes. This shows whether broadcast is merged.
- **Every lane on one word** must cost a single pass.
- **A conflicting group masked off** must stay free and return zeros.
- **A scattered pseudo-random pattern** checks the maximum-per-bank cost against the model.

On the write side:
- **Several lanes writing one word**, then read back, exposes whether the lowest lane really wins.
- **A write injected while busy**, then read back, shows whether a mid-operation request is dropped.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRN1  = 2'd2,
    ST_DRN2  = 2'd3
  } bcr_state_e;
endpackage

// File: rtl/bcr_picker.sv
// Selects, per bank, the word of the lowest pending lane and grants every
// pending lane that addresses that same word.
module bcr_picker #(
  parameter int LANES  = 32,
  parameter int BANKS  = 32,
  parameter int ADDR_W = 9,
  parameter int DATA_W = 32,
  localparam int BB    = $clog2(BANKS),
  localparam int ROW_W = ADDR_W - BB
) (
  input  logic [LANES-1:0]        pend,
  input  logic [LANES*ADDR_W-1:0] addr,
  input  logic [LANES*DATA_W-1:0] wdata,
  output logic [LANES-1:0]        grant,
  output logic [BANKS-1:0]        sel_en,
  output logic [BANKS*ROW_W-1:0]  sel_row,
  output logic [BANKS*DATA_W-1:0] sel_wd
);
  logic [ADDR_W-1:0] sel_addr [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic              hit;
    logic [ADDR_W-1:0] sa;
    logic [DATA_W-1:0] sw;
    always_comb begin
      hit = 1'b0;
      sa  = '0;
      sw  = '0;
      // descending scan: the last match seen is the lowest lane
      for (int l = LANES - 1; l >= 0; l--) begin
        if (pend[l] && addr[l*ADDR_W +: BB] == BB'(b)) begin
          hit = 1'b1;
          sa  = addr[l*ADDR_W +: ADDR_W];
          sw  = wdata[l*DATA_W +: DATA_W];
        end
      end
    end
    assign sel_addr[b]                   = sa;
    assign sel_en[b]                     = hit;
    assign sel_row[b*ROW_W +: ROW_W]     = sa[ADDR_W-1:BB];
    assign sel_wd[b*DATA_W +: DATA_W]    = sw;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [ADDR_W-1:0] la;
    assign la       = addr[l*ADDR_W +: ADDR_W];
    assign grant[l] = pend[l] && (la == sel_addr[la[BB-1:0]]);
  end
endmodule

// File: rtl/bcr_bank.sv
// One single-port bank, read-first, registered read data (block RAM style).
module bcr_bank #(
  parameter int ROWS   = 16,
  parameter int DATA_W = 32,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ROW_W-1:0]  row,
  input  logic [DATA_W-1:0] wd,
  output logic [DATA_W-1:0] rd
);
  logic [DATA_W-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[row] <= wd;
      rd <= mem[row];
    end
  end
endmodule

// File: rtl/bank_conflict_resolver.sv
module bank_conflict_resolver
  import bcr_pkg::*;
#(
  parameter int LANES  = 32,
  parameter int BANKS  = 32,
  parameter int ROWS   = 16,
  parameter int DATA_W = 32,
  localparam int BB     = $clog2(BANKS),
  localparam int ROW_W  = $clog2(ROWS),
  localparam int ADDR_W = BB + ROW_W,
  localparam int CNT_W  = $clog2(LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic [LANES-1:0]        req_mask,
  input  logic [LANES*ADDR_W-1:0] req_addr,
  input  logic [LANES*DATA_W-1:0] req_wdata,
  output logic                    busy,
  output logic                    done,
  output logic [CNT_W-1:0]        cycles,
  output logic [BANKS-1:0]        bank_en,
  output logic [BANKS*ROW_W-1:0]  bank_row,
  output logic [LANES*DATA_W-1:0] rdata
);
  bcr_state_e              state_q;
  logic [LANES-1:0]        pend_q, g1_q, g2_q;
  logic                    wr_q;
  logic [LANES*ADDR_W-1:0] addr_q;
  logic [LANES*DATA_W-1:0] wd_q, rdata_q;
  logic [CNT_W-1:0]        cnt_q, cycles_q;
  logic [BANKS-1:0]        en_q, we_q;
  logic [BANKS*ROW_W-1:0]  row_q;
  logic [BANKS*DATA_W-1:0] bwd_q;
  logic                    busy_q, done_q;

  logic [LANES-1:0]        pend_run, pick_grant, pend_next;
  logic [BANKS-1:0]        pick_en;
  logic [BANKS*ROW_W-1:0]  pick_row;
  logic [BANKS*DATA_W-1:0] pick_wd;
  logic [DATA_W-1:0]       bank_rd [BANKS];

  assign pend_run  = (state_q == ST_RUN) ? pend_q : '0;
  assign pend_next = pend_q & ~pick_grant;

  bcr_picker #(
    .LANES(LANES), .BANKS(BANKS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_picker (
    .pend    (pend_run),
    .addr    (addr_q),
    .wdata   (wd_q),
    .grant   (pick_grant),
    .sel_en  (pick_en),
    .sel_row (pick_row),
    .sel_wd  (pick_wd)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_mem
    bcr_bank #(.ROWS(ROWS), .DATA_W(DATA_W)) u_bank (
      .clk (clk),
      .en  (en_q[b]),
      .we  (we_q[b]),
      .row (row_q[b*ROW_W +: ROW_W]),
      .wd  (bwd_q[b*DATA_W +: DATA_W]),
      .rd  (bank_rd[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      pend_q   <= '0;
      g1_q     <= '0;
      g2_q     <= '0;
      wr_q     <= 1'b0;
      addr_q   <= '0;
      wd_q     <= '0;
      rdata_q  <= '0;
      cnt_q    <= '0;
      cycles_q <= '0;
      en_q     <= '0;
      we_q     <= '0;
      row_q    <= '0;
      bwd_q    <= '0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      g2_q   <= g1_q;
      // return data two cycles after the pass that granted the lane
      for (int l = 0; l < LANES; l++) begin
        if (g2_q[l] && !wr_q)
          rdata_q[l*DATA_W +: DATA_W] <= bank_rd[addr_q[l*ADDR_W +: BB]];
      end
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            pend_q  <= req_mask;
            addr_q  <= req_addr;
            wd_q    <= req_wdata;
            wr_q    <= req_write;
            cnt_q   <= '0;
            rdata_q <= '0;
            busy_q  <= 1'b1;
            state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          en_q   <= pick_en;
          we_q   <= pick_en & {BANKS{wr_q}};
          row_q  <= pick_row;
          bwd_q  <= pick_wd;
          g1_q   <= pick_grant;
          pend_q <= pend_next;
          if (pend_q != '0) cnt_q <= cnt_q + CNT_W'(1);
          if (pend_next == '0) state_q <= ST_DRN1;
        end
        ST_DRN1: begin
          en_q    <= '0;
          we_q    <= '0;
          g1_q    <= '0;
          state_q <= ST_DRN2;
        end
        default: begin
          busy_q   <= 1'b0;
          done_q   <= 1'b1;
          cycles_q <= cnt_q;
          state_q  <= ST_IDLE;
        end
      endcase
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign cycles   = cycles_q;
  assign bank_en  = en_q;
  assign bank_row = row_q;
  assign rdata    = rdata_q;
endmodule

// File: rtl/bcr_checker.sv
module bcr_checker #(
  parameter int LANES = 32,
  parameter int BANKS = 32,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             busy,
  input logic             done,
  input logic [CNT_W-1:0] cycles,
  input logic [BANKS-1:0] bank_en
);
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    !busy |-> bank_en == '0);

  p_done_ends_busy_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_cycles_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(cycles));

  p_start_needs_req_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req_valid));

  p_cost_bound_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> cycles <= CNT_W'(LANES));
endmodule

bind bank_conflict_resolver bcr_checker #(
  .LANES(LANES), .BANKS(BANKS), .CNT_W(CNT_W)
) u_bcr_checker (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .busy      (busy),
  .done      (done),
  .cycles    (cycles),
  .bank_en   (bank_en)
);

// File: tb/bank_conflict_resolver_tb_top.sv
module bank_conflict_resolver_tb_top;
  localparam int LANES  = 32;
  localparam int BANKS  = 32;
  localparam int ROWS   = 16;
  localparam int DATA_W = 32;
  localparam int ROW_W  = 4;
  localparam int ADDR_W = 9;
  localparam int CNT_W  = 6;
  localparam int WORDS  = BANKS * ROWS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [LANES-1:0]        req_mask = '0;
  logic [LANES*ADDR_W-1:0] req_addr = '0;
  logic [LANES*DATA_W-1:0] req_wdata = '0;
  logic                    busy, done;
  logic [CNT_W-1:0]        cycles;
  logic [BANKS-1:0]        bank_en;
  logic [BANKS*ROW_W-1:0]  bank_row;
  logic [LANES*DATA_W-1:0] rdata;

  always #5 clk = ~clk;

  bank_conflict_resolver #(
    .LANES(LANES), .BANKS(BANKS), .ROWS(ROWS), .DATA_W(DATA_W)
  ) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_mask(req_mask), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .cycles(cycles), .bank_en(bank_en),
    .bank_row(bank_row), .rdata(rdata)
  );

  typedef struct {
    int                      cyc;
    int                      blen;
    logic [LANES*DATA_W-1:0] rd;
    string                   tag;
  } exp_t;

  exp_t              sb[$];
  int                n_tests = 0, n_fail = 0;
  logic [DATA_W-1:0] model [WORDS];
  int                lane_addr [LANES];
  logic [DATA_W-1:0] lane_wd [LANES];
  int                bcnt = 0;
  bit                finished = 1'b0;

  task automatic check(string req, logic [LANES*DATA_W-1:0] act,
                       logic [LANES*DATA_W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // driver: computes the expected outcome, pushes it, then drives the request
  task automatic run_op(bit wr, logic [LANES-1:0] m, string tag, bit inject);
    exp_t e;
    int   cost = 0;
    for (int b = 0; b < BANKS; b++) begin
      int uniq = 0;
      for (int l = 0; l < LANES; l++) begin
        if (m[l] && (lane_addr[l] % BANKS) == b) begin
          bit seen = 1'b0;
          for (int j = 0; j < l; j++)
            if (m[j] && lane_addr[j] == lane_addr[l]) seen = 1'b1;
          if (!seen) uniq++;
        end
      end
      if (uniq > cost) cost = uniq;
    end
    e.cyc  = cost;
    e.blen = ((cost == 0) ? 1 : cost) + 2;
    e.rd   = '0;
    e.tag  = tag;
    for (int l = 0; l < LANES; l++)
      if (!wr && m[l]) e.rd[l*DATA_W +: DATA_W] = model[lane_addr[l]];
    if (wr)
      for (int l = LANES - 1; l >= 0; l--)
        if (m[l]) model[lane_addr[l]] = lane_wd[l];
    sb.push_back(e);

    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_mask  = m;
    for (int l = 0; l < LANES; l++) begin
      req_addr[l*ADDR_W +: ADDR_W]  = ADDR_W'(lane_addr[l]);
      req_wdata[l*DATA_W +: DATA_W] = lane_wd[l];
    end
    @(negedge clk);
    req_valid = 1'b0;
    if (inject) begin
      // R9: a write while busy must be dropped
      req_valid = 1'b1;
      req_write = 1'b1;
      req_mask  = '1;
      for (int l = 0; l < LANES; l++) begin
        req_addr[l*ADDR_W +: ADDR_W]  = ADDR_W'(l);
        req_wdata[l*DATA_W +: DATA_W] = 32'hDEAD_BEEF;
      end
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: pops the scoreboard on every completion
  always @(negedge clk) begin
    if (!rst) begin
      if (busy) bcnt++;
      if (done) begin
        if (sb.size() == 0) begin
          n_tests++; n_fail++;
          $display("FAIL R6 unexpected done act=1 exp=0");
        end else begin
          exp_t e;
          e = sb.pop_front();
          check({e.tag, " R3 cycles"}, (LANES*DATA_W)'(cycles), (LANES*DATA_W)'(e.cyc));
          check({e.tag, " R6 busy length"}, (LANES*DATA_W)'(bcnt), (LANES*DATA_W)'(e.blen));
          check({e.tag, " R7 rdata"}, rdata, e.rd);
        end
        bcnt = 0;
      end
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 reset busy/done/cycles/bank_en",
          (LANES*DATA_W)'({busy, done, cycles, bank_en}), '0);
    check("R10 reset rdata", rdata, '0);
    rst = 1'b0;
    @(negedge clk);

    // fill: conflict-free writes, each lane in its own bank (R1, R2, R8)
    for (int k = 0; k < ROWS; k++) begin
      for (int l = 0; l < LANES; l++) begin
        lane_addr[l] = k * BANKS + l;
        lane_wd[l]   = 32'hC0DE_0000 | DATA_W'(k * BANKS + l);
      end
      run_op(1'b1, '1, "R2 R8 fill", 1'b0);
    end

    // unit stride read, one pass (R2, R7)
    for (int l = 0; l < LANES; l++) lane_addr[l] = 3 * BANKS + l;
    run_op(1'b0, '1, "R2 R7 stride1", 1'b0);

    // stride 2: even banks, two words each (R1, R3)
    for (int l = 0; l < LANES; l++) lane_addr[l] = 2 * l;
    run_op(1'b0, '1, "R1 R3 stride2", 1'b0);

    // all lanes on bank 0, pairs share a word: 16 passes (R3, R4)
    for (int l = 0; l < LANES; l++) lane_addr[l] = BANKS * (l % 16) + 0;
    run_op(1'b0, '1, "R3 R4 bank0 fold", 1'b0);

    // every lane on one word: broadcast, one pass (R4)
    for (int l = 0; l < LANES; l++) lane_addr[l] = 77;
    run_op(1'b0, '1, "R4 broadcast", 1'b0);

    // conflicting upper half masked off (R5)
    for (int l = 0; l < LANES; l++) lane_addr[l] = (l < 16) ? l : (l - 16 + BANKS);
    run_op(1'b0, 32'h0000_FFFF, "R5 masked conflict", 1'b0);

    // empty mask (R11)
    run_op(1'b0, '0, "R11 empty", 1'b0);

    // three lanes write one word, lowest wins (R8)
    for (int l = 0; l < LANES; l++) begin
      lane_addr[l] = 100;
      lane_wd[l]   = 32'h1111_0000 | DATA_W'(l);
    end
    run_op(1'b1, 32'h0000_0221, "R8 dup write", 1'b0);
    run_op(1'b0, '1, "R8 dup readback", 1'b0);

    // 4-way conflicting write then read back (R3, R8)
    for (int l = 0; l < LANES; l++) begin
      lane_addr[l] = BANKS * (l / 8) + (l % 8) + 200;
      lane_wd[l]   = 32'hABCD_0000 | DATA_W'(l * 3);
    end
    run_op(1'b1, '1, "R3 R8 4way write", 1'b0);
    run_op(1'b0, '1, "R3 R7 4way read", 1'b0);

    // request while busy is dropped, then read the words it aimed at (R9)
    for (int l = 0; l < LANES; l++) lane_addr[l] = 2 * l;
    run_op(1'b0, '1, "R9 busy inject", 1'b1);
    for (int l = 0; l < LANES; l++) lane_addr[l] = l;
    run_op(1'b0, '1, "R9 inject readback", 1'b0);

    // scattered pattern (R3, R7)
    for (int l = 0; l < LANES; l++) lane_addr[l] = (l * 37 + l * l * 13) % WORDS;
    run_op(1'b0, 32'hF7DF_7BEF, "R3 R7 scattered", 1'b0);

    repeat (4) @(negedge clk);
    // R6: every accepted request completed exactly once
    check("R6 scoreboard drained", (LANES*DATA_W)'(sb.size()), '0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule